// File: doc/BRIEF.md
# Auto-Modify Side-Effect Log

This block keeps a per-instruction record of the general-register changes made by autoincrement and autodecrement addressing. When a memory fault stops an instruction partway through, a fault handler can use this record to reverse each change. It can then point the program counter back at the saved instruction start and run the instruction again.

A start strobe carrying the instruction's first-word address opens a new record. The strobe clears the status word and the overflow flag and captures the address. Each later update event names a 3-bit register number and a 5-bit two's-complement step. The block packs up to two distinct registers, each with its net change, into one 16-bit status word. An abort input freezes the status word and the start address so that software can read them. A release pulse unfreezes them. A small select-driven read port returns either the status word or the start address.

Top module: `sidefx_log`

## Requirements
- R1: After reset the status word, the start address, the overflow flag and the frozen flag are all zero.
- R2: A start strobe, taken while not frozen and without abort, sets the start address to the strobe's address, the status word to zero and the overflow flag to zero, all from the next cycle. An update in the same cycle as the strobe is logged into the fresh record.
- R3: The first update of a record fills the low slot: the register number goes in bits 2:0 and the step in bits 7:3.
- R4: An update for a register that differs from the low slot's register, while the high slot is empty, fills the high slot: the register number goes in bits 10:8 and the step in bits 15:11.
- R5: An update for a register that already holds a slot adds its step to that slot's amount, modulo 32. The register fields stay unchanged.
- R6: An update for a third distinct register leaves the status word unchanged and sets the overflow flag. The flag stays set until the next accepted start strobe.
- R7: An abort taken while not frozen sets the frozen flag from the next cycle. Start strobes and updates in the abort cycle, and in any frozen cycle, change neither the status word, the start address nor the overflow flag.
- R8: A release while frozen and without abort clears the frozen flag from the next cycle. A release in the same cycle as an abort leaves the block frozen. A release while not frozen has no effect.
- R9: The read port is combinational: a select of 0 returns the status word and a select of 1 returns the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | Start-of-instruction strobe |
| insn_addr | input | 16 | Address of the instruction's first word |
| upd_valid | input | 1 | Register update event |
| upd_reg | input | 3 | Register number changed by the event |
| upd_step | input | 5 | Signed change, two's complement |
| abort_req | input | 1 | Fault abort, freezes the log |
| release_req | input | 1 | Unfreezes the log |
| rd_sel | input | 1 | Read select: 0 status word, 1 start address |
| rd_data | output | 16 | Selected register |
| frozen | output | 1 | Log is frozen |
| ovf_flag | output | 1 | Third distinct register was seen |

## Verification
The hardest state to reach from the ports is a full record that then meets a third distinct register, or an abort that lands in the same cycle as a start strobe or an update. Random stimulus draws register numbers from a narrow set, so repeats, second registers and third registers all occur often. It also raises abort, release and strobes together at random. Directed cases first drive the exact sequences that build a full record, overflow it, and then abort and release it with conflicting inputs in the same cycle.

// File: rtl/sidefx_log.sv
module sidefx_log #(
  parameter int AW = 16,
  parameter int RW = 3,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_start,
  input  logic [AW-1:0] insn_addr,
  input  logic          upd_valid,
  input  logic [RW-1:0] upd_reg,
  input  logic [SW-1:0] upd_step,
  input  logic          abort_req,
  input  logic          release_req,
  input  logic          rd_sel,
  output logic [AW-1:0] rd_data,
  output logic          frozen,
  output logic          ovf_flag
);
  localparam int SLW = RW + SW;
  localparam int WW  = 2 * SLW;

  logic [RW-1:0] reg0, reg1;
  logic [SW-1:0] amt0, amt1;
  logic          used0, used1;
  logic [AW-1:0] start_q;
  logic [WW-1:0] status_w;

  logic          live;
  logic          fresh;
  logic          u0, u1;
  logic          hit0, hit1;

  assign status_w = {amt1, reg1, amt0, reg0};
  assign live  = !frozen && !abort_req;
  assign fresh = live && insn_start;
  assign u0 = used0 && !fresh;
  assign u1 = used1 && !fresh;
  assign hit0 = u0 && (reg0 == upd_reg);
  assign hit1 = u1 && (reg1 == upd_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg0 <= '0; reg1 <= '0; amt0 <= '0; amt1 <= '0;
      used0 <= 1'b0; used1 <= 1'b0;
      start_q <= '0; frozen <= 1'b0; ovf_flag <= 1'b0;
    end else if (frozen) begin
      if (release_req && !abort_req) frozen <= 1'b0;
    end else if (abort_req) begin
      frozen <= 1'b1;
    end else begin
      if (fresh) begin
        start_q <= insn_addr;
        reg0 <= '0; reg1 <= '0; amt0 <= '0; amt1 <= '0;
        used0 <= 1'b0; used1 <= 1'b0; ovf_flag <= 1'b0;
      end
      if (upd_valid) begin
        if (!u0) begin
          reg0 <= upd_reg; amt0 <= upd_step; used0 <= 1'b1;
        end else if (hit0) begin
          amt0 <= amt0 + upd_step;
        end else if (!u1) begin
          reg1 <= upd_reg; amt1 <= upd_step; used1 <= 1'b1;
        end else if (hit1) begin
          amt1 <= amt1 + upd_step;
        end else begin
          ovf_flag <= 1'b1;
        end
      end
    end
  end

  assign rd_data = rd_sel ? start_q : AW'(status_w);
endmodule

module sidefx_log_chk #(
  parameter int AW = 16,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_start,
  input logic [AW-1:0] insn_addr,
  input logic          upd_valid,
  input logic          abort_req,
  input logic          release_req,
  input logic          frozen,
  input logic          ovf_flag,
  input logic [WW-1:0] status_w,
  input logic [AW-1:0] start_q
);
  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(status_w) && $stable(start_q) && $stable(ovf_flag)));
  // R7
  abort_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !frozen) |=> (frozen && $stable(status_w) && $stable(start_q)));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && release_req && !abort_req) |=> !frozen);
  // R8
  release_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && abort_req) |=> frozen);
  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && !frozen && !abort_req) |=> (start_q == $past(insn_addr) && !ovf_flag));
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && !upd_valid && !frozen && !abort_req) |=> (status_w == '0));
endmodule

bind sidefx_log sidefx_log_chk #(.AW(AW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_addr(insn_addr),
  .upd_valid(upd_valid), .abort_req(abort_req), .release_req(release_req),
  .frozen(frozen), .ovf_flag(ovf_flag), .status_w(status_w), .start_q(start_q)
);

// File: tb/sidefx_log_bench.sv
module sidefx_log_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_start = 1'b0;
  logic [15:0] insn_addr = '0;
  logic        upd_valid = 1'b0;
  logic [2:0]  upd_reg = '0;
  logic [4:0]  upd_step = '0;
  logic        abort_req = 1'b0;
  logic        release_req = 1'b0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        frozen;
  logic        ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0]  m_r0, m_r1;
  logic [4:0]  m_a0, m_a1;
  bit          m_v0, m_v1, m_ovf, m_frz;
  logic [15:0] m_addr;

  always #10 clk = ~clk;

  sidefx_log u_sidefx_log (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_addr(insn_addr),
    .upd_valid(upd_valid), .upd_reg(upd_reg), .upd_step(upd_step),
    .abort_req(abort_req), .release_req(release_req), .rd_sel(rd_sel),
    .rd_data(rd_data), .frozen(frozen), .ovf_flag(ovf_flag)
  );

  function automatic logic [15:0] exp_status();
    return {m_a1, m_r1, m_a0, m_r0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_r0 = '0; m_r1 = '0; m_a0 = '0; m_a1 = '0;
    m_v0 = 0; m_v1 = 0; m_ovf = 0; m_frz = 0; m_addr = '0;
  endtask

  task automatic model_step();
    if (!rst_n) begin
      model_clear();
    end else if (m_frz) begin
      if (release_req && !abort_req) m_frz = 0;
    end else if (abort_req) begin
      m_frz = 1;
    end else begin
      if (insn_start) begin
        m_addr = insn_addr;
        m_r0 = '0; m_r1 = '0; m_a0 = '0; m_a1 = '0;
        m_v0 = 0; m_v1 = 0; m_ovf = 0;
      end
      if (upd_valid) begin
        if (!m_v0) begin m_r0 = upd_reg; m_a0 = upd_step; m_v0 = 1; end
        else if (m_r0 == upd_reg) m_a0 = m_a0 + upd_step;
        else if (!m_v1) begin m_r1 = upd_reg; m_a1 = upd_step; m_v1 = 1; end
        else if (m_r1 == upd_reg) m_a1 = m_a1 + upd_step;
        else m_ovf = 1;
      end
    end
  endtask

  task automatic check_all(string st_tag);
    rd_sel = 1'b0; #1;
    chk(st_tag, 32'(rd_data), 32'(exp_status()));
    rd_sel = 1'b1; #1;
    chk("R9 start address", 32'(rd_data), 32'(m_addr));
    chk("R6 overflow", 32'(ovf_flag), 32'(m_ovf));
    chk("R8 frozen", 32'(frozen), 32'(m_frz));
    rd_sel = 1'b0;
  endtask

  task automatic tick(string st_tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    insn_start = 0; upd_valid = 0; abort_req = 0; release_req = 0;
    check_all(st_tag);
  endtask

  task automatic upd(logic [2:0] r, logic [4:0] s);
    upd_valid = 1; upd_reg = r; upd_step = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    @(negedge clk);
    tick("R1 reset status");
    tick("R1 reset status");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 status after reset");

    insn_start = 1; insn_addr = 16'h1234;
    tick("R2 start clears status");
    chk("R2 addr captured", 32'(m_addr), 32'h1234);
    upd(3'd3, 5'd2);
    tick("R3 low slot fill");
    chk("R3 expected low slot", 32'(exp_status()), 32'h0013);
    upd(3'd3, 5'd2);
    tick("R5 accumulate low");
    chk("R5 expected sum", 32'(exp_status()), 32'h0023);
    upd(3'd5, 5'b11110);
    tick("R4 high slot fill");
    chk("R4 expected word", 32'(exp_status()), 32'hF523);
    upd(3'd5, 5'b11000);
    tick("R5 accumulate high negative");
    upd(3'd1, 5'd1);
    tick("R6 third register ignored");
    chk("R6 expected flag", 32'(m_ovf), 32'd1);
    abort_req = 1; insn_start = 1; insn_addr = 16'hBEEF; upd(3'd0, 5'd4);
    tick("R7 abort cycle events ignored");
    chk("R7 expected frozen", 32'(m_frz), 32'd1);
    insn_start = 1; insn_addr = 16'h5555; upd(3'd2, 5'd1);
    tick("R7 frozen ignores inputs");
    release_req = 1; abort_req = 1;
    tick("R8 release blocked by abort");
    release_req = 1;
    tick("R8 release unfreezes");
    chk("R8 expected unfrozen", 32'(m_frz), 32'd0);
    release_req = 1;
    tick("R8 idle release no effect");
    insn_start = 1; insn_addr = 16'h0400; upd(3'd6, 5'b11111);
    tick("R2 start with same-cycle update");
    chk("R2 expected fresh slot", 32'(exp_status()), 32'h00FE);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 15) begin insn_start = 1; insn_addr = 16'($urandom); end
      if ($urandom_range(0, 99) < 60)
        upd(3'($urandom_range(0, 3)), 5'($urandom_range(0, 16) - 8));
      if ($urandom_range(0, 99) < 4) abort_req = 1;
      if ($urandom_range(0, 99) < 15) release_req = 1;
      tick("R3 R4 R5 random status");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule